// File: doc/BRIEF.md
# RTP Header Field Inserter

This block finalises the RTP header of an outgoing packet as it is assembled. For each packet the assembler presents the connection number, that connection's settings (encoding selection, a table of payload-type codes, a timestamp offset, a sequence-insert flag and a timestamp-insert flag) and the header words already present in the payload (payload type, sequence number, timestamp) on a valid/ready input. One cycle later the block presents the payload type, sequence number and timestamp to be transmitted.

A global timestamp arrives from the TDM side. It may come from a free-running counter or from four TDM time slots; the block does not care which. A strobe marks the cycle in which the packet's first payload byte was taken, and the block holds the global timestamp seen then. Voice packets take that held value plus the offset. Pass-through traffic can keep its own sequence number and timestamp. With both flags cleared, a zero offset and a keep-own payload type, the header leaves unchanged, so non-RTP packets can use the same path. The block keeps one 16-bit sequence counter for each connection.

Top module: `rtp_field_inserter`

## Requirements
- R1: During reset and in the cycle in which reset is released, `hdr_ready_o` and `out_valid_o` are 0, and every connection's sequence counter is 0000h. From the second clock after release, `hdr_ready_o` is 1.
- R2: When `enc_sel_i` is 0 to 5, `out_pt_o` is the 7-bit entry `pt_table_i[7*k+6:7*k]`, where k is `enc_sel_i`. The encodings are 0 PCM, 1 to 4 ADPCM at 16, 24, 32 and 40 kbit/s, and 5 comfort noise.
- R3: When `enc_sel_i` is 6 or 7, `out_pt_o` is the payload's own `hdr_pt_i`.
- R4: When `ts_ins_i` is 1, `out_ts_o` is the held global timestamp plus `ts_offset_i`, modulo 2^32.
- R5: A high `first_byte_i` loads `gts_i` into the hold register. A packet accepted in that same cycle uses the new `gts_i` value. Otherwise a packet uses the value held from the last strobe, which is 0 after reset.
- R6: When `ts_ins_i` is 0, `out_ts_o` is `hdr_ts_i` plus `ts_offset_i`, modulo 2^32. A zero offset passes the timestamp through unchanged.
- R7: When `seq_ins_i` is 1, `out_seq_o` is the counter of connection `conn_i`. That counter then increments by one and wraps from FFFFh to 0000h.
- R8: When `seq_ins_i` is 0, `out_seq_o` is `hdr_seq_i` and no counter changes.
- R9: Each connection's counter advances only on packets of that connection.
- R10: With both flags at 0, `ts_offset_i` at 0 and `enc_sel_i` at 6 or 7, all three output fields equal the header input.
- R11: `out_valid_o` is high for exactly the cycle after each accepted header. The output fields hold their values while `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gts_i | input | 32 | Global timestamp from the TDM side |
| first_byte_i | input | 1 | Strobe marking the packet's first payload byte |
| hdr_valid_i | input | 1 | Header words and settings valid |
| hdr_ready_o | output | 1 | Block can take a header |
| conn_i | input | 2 | Connection number |
| enc_sel_i | input | 3 | Encoding selection (0 to 5 table, 6 and 7 keep own) |
| pt_table_i | input | 42 | Six 7-bit payload-type codes of the connection |
| ts_offset_i | input | 32 | Connection timestamp offset |
| seq_ins_i | input | 1 | Generate the sequence number |
| ts_ins_i | input | 1 | Use the global timestamp |
| hdr_pt_i | input | 7 | Payload's own payload type |
| hdr_seq_i | input | 16 | Payload's own sequence number |
| hdr_ts_i | input | 32 | Payload's own timestamp |
| out_valid_o | output | 1 | Output fields valid |
| out_pt_o | output | 7 | Final payload type |
| out_seq_o | output | 16 | Final sequence number |
| out_ts_o | output | 32 | Final timestamp |

## Verification
The hidden state is the per-connection counter bank and the held global timestamp. A wrong counter shows up only on the next sequence-inserting packet of that connection, so the bench interleaves connections, inserts pass-through packets between generated ones, and drives a counter through its FFFFh wrap. A stale or badly timed hold register shows up in the first timestamp-inserting packet after a strobe, so strobes are placed both in the packet's own cycle and several cycles before it. Every output is compared with a behavioural model on every clock, so any fault appears in the cycle after the packet that exposes it.

// File: rtl/rtp_ins_pkg.sv
package rtp_ins_pkg;
  localparam int unsigned PT_W    = 7;
  localparam int unsigned SEQ_W   = 16;
  localparam int unsigned TS_W    = 32;
  localparam int unsigned ENC_CNT = 6;
  localparam int unsigned ENC_W   = 3;

  typedef enum logic [ENC_W-1:0] {
    ENC_PCM   = 3'd0,
    ENC_AD16  = 3'd1,
    ENC_AD24  = 3'd2,
    ENC_AD32  = 3'd3,
    ENC_AD40  = 3'd4,
    ENC_CN    = 3'd5,
    ENC_KEEP  = 3'd6,
    ENC_KEEP2 = 3'd7
  } enc_e;
endpackage

// File: rtl/rtp_pt_select.sv
module rtp_pt_select
  import rtp_ins_pkg::*;
(
  input  logic [ENC_W-1:0]        enc_sel_i,
  input  logic [ENC_CNT*PT_W-1:0] pt_table_i,
  input  logic [PT_W-1:0]         hdr_pt_i,
  output logic [PT_W-1:0]         pt_o
);
  always_comb begin
    pt_o = hdr_pt_i;
    for (int k = 0; k < ENC_CNT; k++) begin
      if (enc_sel_i == ENC_W'(k)) pt_o = pt_table_i[k*PT_W +: PT_W];
    end
  end
endmodule

// File: rtl/rtp_ts_former.sv
module rtp_ts_former
  import rtp_ins_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            first_byte_i,
  input  logic [TS_W-1:0] gts_i,
  input  logic            ts_ins_i,
  input  logic [TS_W-1:0] hdr_ts_i,
  input  logic [TS_W-1:0] ts_offset_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] held_q;
  logic [TS_W-1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           held_q <= '0;
    else if (first_byte_i) held_q <= gts_i;
  end

  // same-cycle strobe bypasses the hold register
  always_comb begin
    if (!ts_ins_i)         base = hdr_ts_i;
    else if (first_byte_i) base = gts_i;
    else                   base = held_q;
    ts_o = base + ts_offset_i;
  end
endmodule

// File: rtl/rtp_seq_bank.sv
module rtp_seq_bank
  import rtp_ins_pkg::*;
#(
  parameter int unsigned N_CONN = 4,
  localparam int unsigned CONN_W = (N_CONN > 1) ? $clog2(N_CONN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CONN_W-1:0] conn_i,
  input  logic              bump_i,
  output logic [SEQ_W-1:0]  seq_o
);
  logic [SEQ_W-1:0] cnt_q [N_CONN];

  for (genvar c = 0; c < N_CONN; c++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cnt_q[c] <= '0;
      else if (bump_i && conn_i == CONN_W'(c))     cnt_q[c] <= cnt_q[c] + 1'b1;
    end
  end

  always_comb begin
    seq_o = '0;
    for (int c = 0; c < N_CONN; c++) begin
      if (conn_i == CONN_W'(c)) seq_o = cnt_q[c];
    end
  end
endmodule

// File: rtl/rtp_field_inserter.sv
module rtp_field_inserter
  import rtp_ins_pkg::*;
#(
  parameter int unsigned N_CONN = 4,
  localparam int unsigned CONN_W = (N_CONN > 1) ? $clog2(N_CONN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TS_W-1:0]         gts_i,
  input  logic                    first_byte_i,
  input  logic                    hdr_valid_i,
  output logic                    hdr_ready_o,
  input  logic [CONN_W-1:0]       conn_i,
  input  logic [ENC_W-1:0]        enc_sel_i,
  input  logic [ENC_CNT*PT_W-1:0] pt_table_i,
  input  logic [TS_W-1:0]         ts_offset_i,
  input  logic                    seq_ins_i,
  input  logic                    ts_ins_i,
  input  logic [PT_W-1:0]         hdr_pt_i,
  input  logic [SEQ_W-1:0]        hdr_seq_i,
  input  logic [TS_W-1:0]         hdr_ts_i,
  output logic                    out_valid_o,
  output logic [PT_W-1:0]         out_pt_o,
  output logic [SEQ_W-1:0]        out_seq_o,
  output logic [TS_W-1:0]         out_ts_o
);
  logic             live_q;
  logic             take;
  logic [PT_W-1:0]  pt_d;
  logic [SEQ_W-1:0] gen_seq;
  logic [TS_W-1:0]  ts_d;

  assign hdr_ready_o = live_q;
  assign take        = hdr_valid_i & live_q;

  rtp_pt_select u_pt (
    .enc_sel_i (enc_sel_i),
    .pt_table_i(pt_table_i),
    .hdr_pt_i  (hdr_pt_i),
    .pt_o      (pt_d)
  );

  rtp_ts_former u_ts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .first_byte_i(first_byte_i),
    .gts_i       (gts_i),
    .ts_ins_i    (ts_ins_i),
    .hdr_ts_i    (hdr_ts_i),
    .ts_offset_i (ts_offset_i),
    .ts_o        (ts_d)
  );

  rtp_seq_bank #(.N_CONN(N_CONN)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .conn_i(conn_i),
    .bump_i(take & seq_ins_i),
    .seq_o (gen_seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_pt_o    <= '0;
      out_seq_o   <= '0;
      out_ts_o    <= '0;
    end else begin
      live_q      <= 1'b1;
      out_valid_o <= take;
      if (take) begin
        out_pt_o  <= pt_d;
        out_seq_o <= seq_ins_i ? gen_seq : hdr_seq_i;
        out_ts_o  <= ts_d;
      end
    end
  end
endmodule

// File: rtl/rtp_field_inserter_chk.sv
module rtp_field_inserter_chk
  import rtp_ins_pkg::*;
#(
  parameter int unsigned N_CONN = 4,
  localparam int unsigned CONN_W = (N_CONN > 1) ? $clog2(N_CONN) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hdr_valid_i,
  input logic              hdr_ready_o,
  input logic [ENC_W-1:0]  enc_sel_i,
  input logic              seq_ins_i,
  input logic              ts_ins_i,
  input logic [TS_W-1:0]   ts_offset_i,
  input logic [PT_W-1:0]   hdr_pt_i,
  input logic [SEQ_W-1:0]  hdr_seq_i,
  input logic [TS_W-1:0]   hdr_ts_i,
  input logic              out_valid_o,
  input logic [PT_W-1:0]   out_pt_o,
  input logic [SEQ_W-1:0]  out_seq_o,
  input logic [TS_W-1:0]   out_ts_o
);
  // R11
  valid_follows_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(hdr_valid_i && hdr_ready_o));

  // R11
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_pt_o) && $stable(out_seq_o) && $stable(out_ts_o)));

  // R3
  keep_pt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(enc_sel_i) >= 3'd6) |-> out_pt_o == $past(hdr_pt_i));

  // R8
  keep_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(seq_ins_i)) |-> out_seq_o == $past(hdr_seq_i));

  // R6
  own_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(ts_ins_i)) |-> out_ts_o == $past(hdr_ts_i) + $past(ts_offset_i));

  // R1
  ready_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> hdr_ready_o);
endmodule

bind rtp_field_inserter rtp_field_inserter_chk #(.N_CONN(N_CONN)) u_chk (.*);

// File: tb/rtp_field_inserter_tb_top.sv
module rtp_field_inserter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gts = '0;
  logic        fb = 1'b0;
  logic        hv = 1'b0;
  logic        hr;
  logic [1:0]  conn = '0;
  logic [2:0]  enc = '0;
  logic [41:0] ptab;
  logic [31:0] off = '0;
  logic        sins = 1'b0;
  logic        tins = 1'b0;
  logic [6:0]  hpt = '0;
  logic [15:0] hseq = '0;
  logic [31:0] hts = '0;
  logic        ov;
  logic [6:0]  opt;
  logic [15:0] oseq;
  logic [31:0] ots;

  int checks = 0;
  int errors = 0;

  // reference state
  int unsigned seq_ref [4];
  logic [31:0] held_ref = '0;
  logic        e_v = 1'b0;
  logic [6:0]  e_pt = '0;
  logic [15:0] e_seq = '0;
  logic [31:0] e_ts = '0;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  rtp_field_inserter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gts_i(gts), .first_byte_i(fb),
    .hdr_valid_i(hv), .hdr_ready_o(hr), .conn_i(conn), .enc_sel_i(enc),
    .pt_table_i(ptab), .ts_offset_i(off), .seq_ins_i(sins), .ts_ins_i(tins),
    .hdr_pt_i(hpt), .hdr_seq_i(hseq), .hdr_ts_i(hts),
    .out_valid_o(ov), .out_pt_o(opt), .out_seq_o(oseq), .out_ts_o(ots)
  );

  function automatic logic [6:0] tab_code(int k);
    return 7'(8'h60 + 8'(k * 3));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare previous cycle's expectation, then drive the next cycle
  task automatic step(logic v, logic [1:0] c, logic [2:0] e, logic si, logic ti,
                      logic [31:0] o, logic [6:0] p, logic [15:0] s, logic [31:0] t,
                      logic f, logic [31:0] g, string tag);
    @(negedge clk);
    chk({e_tag, " valid"}, 32'(ov), 32'(e_v));
    if (e_v) begin
      chk({e_tag, " pt"}, 32'(opt), 32'(e_pt));
      chk({e_tag, " seq"}, 32'(oseq), 32'(e_seq));
      chk({e_tag, " ts"}, ots, e_ts);
    end
    hv = v; conn = c; enc = e; sins = si; tins = ti; off = o;
    hpt = p; hseq = s; hts = t; fb = f; gts = g;
    if (f) held_ref = g;
    e_v = v;
    e_tag = tag;
    if (v) begin
      e_pt  = (e < 3'd6) ? tab_code(int'(e)) : p;
      e_ts  = (ti ? held_ref : t) + o;
      if (si) begin
        e_seq = 16'(seq_ref[c]);
        seq_ref[c] = (seq_ref[c] + 1) % 65536;
      end else begin
        e_seq = s;
      end
    end
  endtask

  task automatic idle(string tag);
    step(1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, tag);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) ptab[k*7 +: 7] = tab_code(k);
    for (int c = 0; c < 4; c++) seq_ref[c] = 0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(hr), 32'h0);
    chk("R1 valid in reset", 32'(ov), 32'h0);
    rst_n = 1'b1;
    chk("R1 ready at release", 32'(hr), 32'h0);
    @(negedge clk);
    chk("R1 ready after release", 32'(hr), 32'h1);
    e_v = 1'b0; e_tag = "R1";
    // R2 every table entry; R7 counter from 0; R4 held value 0 after reset
    for (int k = 0; k < 6; k++)
      step(1'b1, 2'd0, 3'(k), 1'b1, 1'b1, 32'd100, 7'h11, 16'h1234, 32'h0, 1'b0, gts, "R2 R7 R4");
    idle("R11");
    idle("R11");
    // R5 strobe earlier, then packet uses held value
    step(1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b1, 32'hABCD_0000, "R5");
    step(1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, 32'h1111_1111, "R5");
    step(1'b1, 2'd1, 3'd0, 1'b1, 1'b1, 32'h10, 7'h0, 16'h0, 32'h0, 1'b0, 32'h2222_2222, "R5 R4");
    // R5 same-cycle strobe
    step(1'b1, 2'd1, 3'd5, 1'b1, 1'b1, 32'h20, 7'h0, 16'h0, 32'h0, 1'b1, 32'h5555_0000, "R5 same cycle");
    // R4 modulo wrap
    step(1'b1, 2'd2, 3'd1, 1'b1, 1'b1, 32'hFFFF_FFF0, 7'h0, 16'h0, 32'h0, 1'b1, 32'h0000_0020, "R4 wrap");
    // R6 own timestamp with offset and wrap
    step(1'b1, 2'd2, 3'd2, 1'b1, 1'b0, 32'h8000_0001, 7'h0, 16'h0, 32'h9000_0000, 1'b0, gts, "R6");
    step(1'b1, 2'd2, 3'd2, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'hDEAD_BEEF, 1'b0, gts, "R6 zero offset");
    // R3 keep own pt, R8 keep seq without bumping
    step(1'b1, 2'd0, 3'd6, 1'b0, 1'b1, 32'h5, 7'h2A, 16'hBEEF, 32'h0, 1'b0, gts, "R3 R8");
    step(1'b1, 2'd0, 3'd7, 1'b0, 1'b0, 32'h5, 7'h7F, 16'h0042, 32'h7, 1'b0, gts, "R3 R8");
    // R8 counter untouched, R9 other connections independent
    step(1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, "R8 R9");
    step(1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, "R9");
    step(1'b1, 2'd1, 3'd0, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, "R9");
    // R10 transparent
    step(1'b1, 2'd2, 3'd6, 1'b0, 1'b0, 32'h0, 7'h33, 16'hCAFE, 32'h0102_0304, 1'b1, 32'h9999_9999, "R10");
    idle("R11");
    // R7 wrap on connection 3: drive 65535 more bumps back to back
    for (int i = 0; i < 65535; i++)
      step(1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'(i), 1'b0, gts, "R7 run");
    step(1'b1, 2'd3, 3'd4, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, "R7 after wrap");
    step(1'b1, 2'd0, 3'd3, 1'b1, 1'b0, 32'h0, 7'h0, 16'h0, 32'h0, 1'b0, gts, "R9 after wrap");
    idle("R11");
    idle("R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule